// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing half of a 1024-byte serial EEPROM. It watches a two-wire (I2C) bus, brings SCL and SDA into the system clock domain, finds START and STOP conditions, and then takes in bytes one bit per SCL high phase. The first byte after START selects the device and the direction. In a write, the next byte sets the low part of the address pointer and the bytes after it are data. The controller answers each byte on the ninth clock by pulling SDA low through an open-drain enable. In a read, it shifts memory bytes out, MSB first, through the same enable.

Written bytes collect in a 16-byte page buffer. A STOP hands that buffer to a timed write engine, which commits it to the memory array once its cycle count has run out. While the engine is busy, the controller refuses its own control byte, so a master can poll until the write has finished. A write-protect input lets a transfer run as far as the address phase and then refuses the data.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A control byte is acknowledged on the ninth SCL clock only when bits [7:4] equal 4'b1010 and bit 3 equals `dev_a2`. Bits [2:1] are the block number and bit 0 selects read (1) or write (0). Any other control byte gets no acknowledge, and the slave ignores the bus until the next START.
- R2: While a write cycle is in progress, every control byte is left unacknowledged, even one that matches. The first control byte after the cycle ends is acknowledged.
- R3: In a write transfer, the byte after the control byte is acknowledged and becomes the word address. The 10-bit memory address is {control bits [2:1], word address}.
- R4: Each data byte in a write is acknowledged and lands at the current pointer. Only pointer bits [3:0] then advance, wrapping inside the 16-byte page while bits [9:4] hold. A write longer than 16 bytes overwrites the bytes it received earlier.
- R5: A STOP that follows at least one acknowledged data byte starts a write cycle of `WR_CYCLES` clocks. The memory shows the new data only after that cycle. A repeated START before the STOP discards the buffered data, and no cycle starts.
- R6: With `wp_en` high, the control byte and the word address are still acknowledged. The first data byte is not acknowledged, the following STOP starts no write cycle, and the memory is left unchanged.
- R7: A read control byte returns the byte at the pointer, whose bits [9:8] are replaced by control bits [2:1]. After each byte the full 10-bit pointer advances, wrapping from 0x3FF to 0x000. A read with no address phase continues from where the last access left off.
- R8: A random read is a write header with a word address, then a repeated START and a read control byte. It returns the byte at that address.
- R9: A read keeps sending bytes while the master acknowledges them. After a master NACK the slave leaves SDA released until the next START.
- R10: A START or STOP in the middle of a byte abandons the transfer. The partial byte is never stored, no write cycle starts, and SDA is released.
- R11: After reset, `sda_oe` is low. It changes only while SCL is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| dev_a2 | input | 1 | Strap compared with control byte bit 3 |
| wp_en | input | 1 | Write protect; 1 refuses data bytes |

## Verification
A wrong pointer shows as the wrong byte in the very next read. Page wraparound and the 0x3FF-to-0x000 wrap are therefore covered by sweeping a whole memory region and reading it back in one long sequential read, so an error appears within one byte time of the address that went wrong. A wrong busy or write-protect state shows within the same byte: the ninth-clock acknowledge on SDA comes out wrong, and a write that should not have happened changes the read-back value. A bit-counter slip moves the acknowledge off the ninth clock, which the master sees straight away as a missing acknowledge.

// File: rtl/i2c_eep_pkg.sv
// Shared constants and transfer-state type for the serial EEPROM slave.
package i2c_eep_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA
    } xfer_st_t;
endpackage

// File: rtl/i2c_line_mon.sv
// Bus line monitor: brings SCL/SDA into the clk domain and flags SCL edges,
// START and STOP. Assumes clk is several times faster than SCL and that
// both lines are high while idle.
module i2c_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchronizer chains plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_sync[SYNC_STAGES-1];
    assign sda_lvl   = sda_sync[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/eep_page_store.sv
// Page buffer, timed write engine and byte array. Assumes the protocol side
// raises wr_start only while idle; commits every buffered byte at the end of
// a WR_CYCLES-long busy period. Read port is combinational.
module eep_page_store #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 2000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_clr,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_din,
    input  logic                     wr_start,
    input  logic [ADDR_W-PAGE_W-1:0] wr_page,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int CNT_W      = $clog2(WR_CYCLES + 1);

    logic [7:0]               mem  [DEPTH];
    logic [7:0]               pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]    pvalid;
    logic [CNT_W-1:0]         tmr;
    logic [ADDR_W-PAGE_W-1:0] page_q;
    logic                     commit;

    assign commit = busy && (tmr == '0);

    // Write-cycle timer: latch the page on start, count down, then release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            tmr    <= '0;
            page_q <= '0;
        end else if (wr_start && !busy) begin
            busy   <= 1'b1;
            tmr    <= CNT_W'(WR_CYCLES - 1);
            page_q <= wr_page;
        end else if (commit) begin
            busy <= 1'b0;
        end else if (busy) begin
            tmr <= tmr - 1'b1;
        end
    end

    // Valid mask of page-buffer slots filled since the last address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pvalid <= '0;
        end else if (buf_clr || commit) begin
            pvalid <= '0;
        end else if (buf_we) begin
            pvalid[buf_idx] <= 1'b1;
        end
    end

    // Page-buffer data capture.
    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_din;
    end

    // Commit of all valid slots into the array at the end of the cycle.
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pvalid[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    AST_BUSY_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy); // R5
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> !busy); // R2
    AST_NO_FILL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !busy); // R2
endmodule

// File: rtl/i2c_eep_fsm.sv
// Byte framing, ACK decisions and pointer management for the EEPROM slave.
// Assumes event strobes from i2c_line_mon; changes sda_oe only on SCL fall
// events (or releases it on START/STOP). bit count: rises 1..8 are data,
// rise 9 is the acknowledge slot.
module i2c_eep_fsm
    import i2c_eep_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_lvl,
    input  logic                     sda_lvl,
    input  logic                     scl_rise,
    input  logic                     scl_fall,
    input  logic                     start_det,
    input  logic                     stop_det,
    input  logic                     dev_a2,
    input  logic                     wp_en,
    input  logic                     store_busy,
    input  logic [7:0]               rd_data,
    output logic                     sda_oe,
    output logic [ADDR_W-1:0]        ptr,
    output logic                     buf_clr,
    output logic                     buf_we,
    output logic [PAGE_W-1:0]        buf_idx,
    output logic [7:0]               buf_din,
    output logic                     wr_start,
    output logic [ADDR_W-PAGE_W-1:0] wr_page
);
    localparam int WORD_W = 8;
    localparam int BLK_W  = ADDR_W - WORD_W;

    xfer_st_t   st;
    xfer_st_t   nxt_st;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic       have_data;
    logic       ctrl_hit;
    logic       byte_end;
    logic       ack_now;

    assign ctrl_hit = (shreg[7:4] == DEV_CODE) && (shreg[3] == dev_a2);
    assign byte_end = scl_fall && (cnt == 4'd8);

    // Acknowledge decision for a just-received byte.
    always_comb begin
        case (st)
            ST_CTRL:  ack_now = ctrl_hit && !store_busy;
            ST_WADDR: ack_now = 1'b1;
            ST_WDATA: ack_now = !wp_en;
            default:  ack_now = 1'b0;
        endcase
    end

    assign buf_we   = byte_end && (st == ST_WDATA) && !wp_en;
    assign buf_clr  = byte_end && (st == ST_WADDR);
    assign buf_idx  = ptr[PAGE_W-1:0];
    assign buf_din  = shreg;
    assign wr_start = stop_det && have_data;
    assign wr_page  = ptr[ADDR_W-1:PAGE_W];

    // Transfer sequencing: bit shifting, ACK drive, pointer updates, read out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            nxt_st    <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            tx        <= '0;
            sda_oe    <= 1'b0;
            ptr       <= '0;
            have_data <= 1'b0;
        end else if (start_det) begin
            st        <= ST_CTRL;
            cnt       <= '0;
            sda_oe    <= 1'b0;
            have_data <= 1'b0;
        end else if (stop_det) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            sda_oe    <= 1'b0;
            have_data <= 1'b0;
        end else if (st != ST_IDLE) begin
            if (scl_rise) begin
                if (cnt < 4'd8) shreg <= {shreg[6:0], sda_lvl};
                if (cnt == 4'd8 && st == ST_RDATA) nxt_st <= sda_lvl ? ST_IDLE : ST_RDATA;
                if (cnt < 4'd9) cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
                if (cnt == 4'd8) begin
                    if (st == ST_RDATA) begin
                        sda_oe <= 1'b0;
                    end else begin
                        sda_oe <= ack_now;
                        nxt_st <= ST_IDLE;
                        if (ack_now) begin
                            case (st)
                                ST_CTRL: begin
                                    ptr[ADDR_W-1:WORD_W] <= shreg[BLK_W:1];
                                    nxt_st <= shreg[0] ? ST_RDATA : ST_WADDR;
                                end
                                ST_WADDR: begin
                                    ptr[WORD_W-1:0] <= shreg;
                                    nxt_st <= ST_WDATA;
                                end
                                ST_WDATA: begin
                                    ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                                    have_data <= 1'b1;
                                    nxt_st <= ST_WDATA;
                                end
                                default: ;
                            endcase
                        end
                    end
                end else if (cnt == 4'd9) begin
                    cnt <= '0;
                    st  <= nxt_st;
                    if (nxt_st == ST_RDATA) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= ptr + 1'b1;
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end else if (st == ST_RDATA && cnt != 4'd0) begin
                    tx     <= {tx[6:0], 1'b0};
                    sda_oe <= ~tx[6];
                end
            end
        end
    end

    AST_OE_MOVES_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_det && !stop_det && (sda_oe != $past(sda_oe))) |-> !scl_lvl); // R11
    AST_BUSY_CTRL_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && st == ST_CTRL && store_busy) |=> !sda_oe); // R2
    AST_PAGE_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))); // R4
endmodule

// File: rtl/i2c_eeprom_slave.sv
// Top of the serial EEPROM slave: line monitor, protocol engine and the
// page store with its write timer. SDA is open drain: sda_oe=1 pulls low.
module i2c_eeprom_slave #(
    parameter int ADDR_W      = 10,
    parameter int PAGE_W      = 4,
    parameter int WR_CYCLES   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    input  logic dev_a2,
    input  logic wp_en
);
    logic                     scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic                     start_det, stop_det;
    logic                     store_busy, buf_clr, buf_we, wr_start;
    logic [PAGE_W-1:0]        buf_idx;
    logic [7:0]               buf_din, rd_data;
    logic [ADDR_W-1:0]        ptr;
    logic [ADDR_W-PAGE_W-1:0] wr_page;

    i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_eep_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .dev_a2(dev_a2), .wp_en(wp_en),
        .store_busy(store_busy), .rd_data(rd_data), .sda_oe(sda_oe),
        .ptr(ptr), .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_din(buf_din), .wr_start(wr_start), .wr_page(wr_page)
    );

    eep_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_idx(buf_idx), .buf_din(buf_din), .wr_start(wr_start),
        .wr_page(wr_page), .rd_addr(ptr), .rd_data(rd_data), .busy(store_busy)
    );
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb;
    localparam int WRC = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic dev_a2 = 1'b1;
    logic wp_en = 1'b0;
    logic sda_oe;
    logic sda_w;

    assign sda_w = sda_m & ~sda_oe;

    i2c_eeprom_slave #(.WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_w),
        .sda_oe(sda_oe), .dev_a2(dev_a2), .wp_en(wp_en)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int oe_bad = 0;
    logic oe_prev = 1'b0;
    logic [7:0] model [1024];

    // R11 monitor: sda_oe must not move while the bus clock is high.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl) oe_bad++;
        oe_prev = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(((a * 37) + (a >> 5)) ^ 8'h5C);
    endfunction

    function automatic logic [7:0] ctl(input bit a2, input logic [1:0] blk, input bit rd);
        return {4'b1010, a2, blk, rd};
    endfunction

    task automatic i2c_start();
        sda_m = 1'b1; tick(3); scl = 1'b1; tick(4);
        sda_m = 1'b0; tick(4); scl = 1'b0; tick(3);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(3); scl = 1'b1; tick(4);
        sda_m = 1'b1; tick(4);
    endtask

    task automatic wbit(input logic v);
        sda_m = v; tick(3); scl = 1'b1; tick(4); scl = 1'b0; tick(3);
    endtask

    task automatic rbit(output logic v);
        sda_m = 1'b1; tick(3); scl = 1'b1; tick(2);
        v = sda_w; tick(2); scl = 1'b0; tick(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic v;
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(v);
        ack = !v;
    endtask

    task automatic recv_byte(input bit ack_m, output logic [7:0] b);
        logic v;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            rbit(v);
            b = {b[6:0], v};
        end
        wbit(!ack_m);
    endtask

    task automatic wait_ready(output int polls);
        bit a;
        polls = 0;
        do begin
            i2c_start(); send_byte(ctl(1'b1, 2'd0, 1'b0), a); i2c_stop();
            polls++;
        end while (!a && polls < 50);
    endtask

    // Write n bytes starting at addr; model follows page wraparound (R4).
    task automatic write_bytes(input logic [9:0] addr, input int n, input int seed);
        bit a;
        i2c_start();
        send_byte(ctl(1'b1, addr[9:8], 1'b0), a); chk(a, "R1 ctrl ack", a, 1);
        send_byte(addr[7:0], a);                  chk(a, "R3 word ack", a, 1);
        for (int i = 0; i < n; i++) begin
            logic [9:0] dst;
            dst = {addr[9:4], 4'(addr[3:0] + i)};
            send_byte(pat(seed + i), a); chk(a, "R4 data ack", a, 1);
            model[dst] = pat(seed + i);
        end
        i2c_stop();
    endtask

    // Random/sequential read of n bytes from addr, compared with the model.
    task automatic read_seq(input logic [9:0] addr, input int n, input string req);
        bit a;
        logic [7:0] b;
        i2c_start();
        send_byte(ctl(1'b1, addr[9:8], 1'b0), a);
        send_byte(addr[7:0], a);
        i2c_start();
        send_byte(ctl(1'b1, addr[9:8], 1'b1), a); chk(a, "R8 read ctrl ack", a, 1);
        for (int i = 0; i < n; i++) begin
            logic [9:0] src;
            src = 10'(addr + i);
            recv_byte(i < n - 1, b);
            chk(b === model[src], req, b, model[src]);
        end
        chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
        i2c_stop();
    endtask

    initial begin
        bit a;
        int polls;
        logic [7:0] b;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        chk(sda_oe == 1'b0, "R11 reset oe", sda_oe, 0);

        // R1: control byte matching
        i2c_start(); send_byte(ctl(1'b0, 2'd0, 1'b0), a); i2c_stop();
        chk(!a, "R1 wrong A2 nack", a, 0);
        i2c_start(); send_byte(8'hB2 | 8'h08, a); i2c_stop();
        chk(!a, "R1 wrong code nack", a, 0);
        i2c_start(); send_byte(ctl(1'b1, 2'd3, 1'b0), a); i2c_stop();
        chk(a, "R1 match ack", a, 1);

        // R2/R5: write then ACK polling
        write_bytes(10'h123, 2, 100);
        i2c_start(); send_byte(ctl(1'b1, 2'd0, 1'b0), a); i2c_stop();
        chk(!a, "R2 busy nack", a, 0);
        wait_ready(polls);
        chk(polls < 50, "R2 ready after cycle", polls, 50);
        read_seq(10'h123, 1, "R8 random read");

        // R7: current-address read continues at 0x124
        i2c_start(); send_byte(ctl(1'b1, 2'd1, 1'b1), a);
        chk(a, "R7 current read ack", a, 1);
        recv_byte(1'b0, b); i2c_stop();
        chk(b === model[10'h124], "R7 current read", b, model[10'h124]);

        // R4: 18 bytes from offset 14 wrap inside the page
        write_bytes(10'h01E, 18, 200);
        wait_ready(polls);
        read_seq(10'h010, 16, "R4 page wrap");

        // R5: repeated START discards buffered data
        write_bytes(10'h040, 1, 300);
        wait_ready(polls);
        i2c_start(); send_byte(ctl(1'b1, 2'd0, 1'b0), a); send_byte(8'h40, a);
        send_byte(8'h99, a); i2c_start(); i2c_stop();
        i2c_start(); send_byte(ctl(1'b1, 2'd0, 1'b0), a); i2c_stop();
        chk(a, "R5 no cycle after restart", a, 1);
        read_seq(10'h040, 1, "R5 data kept");

        // R6: write protect
        wp_en = 1'b1;
        i2c_start();
        send_byte(ctl(1'b1, 2'd0, 1'b0), a); chk(a, "R6 ctrl ack", a, 1);
        send_byte(8'h40, a);                 chk(a, "R6 word ack", a, 1);
        send_byte(8'h77, a);                 chk(!a, "R6 data nack", a, 0);
        i2c_stop();
        wp_en = 1'b0;
        i2c_start(); send_byte(ctl(1'b1, 2'd0, 1'b0), a); i2c_stop();
        chk(a, "R6 no cycle", a, 1);
        read_seq(10'h040, 1, "R6 memory unchanged");

        // R10: STOP in the middle of a data byte
        i2c_start(); send_byte(ctl(1'b1, 2'd0, 1'b0), a); send_byte(8'h40, a);
        wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b0);
        i2c_stop();
        chk(sda_oe == 1'b0, "R10 released", sda_oe, 0);
        i2c_start(); send_byte(ctl(1'b1, 2'd0, 1'b0), a); i2c_stop();
        chk(a, "R10 no cycle", a, 1);
        read_seq(10'h040, 1, "R10 partial dropped");

        // Sweep: page 0 and blocks 2..3, then one long read through the top wrap
        write_bytes(10'h000, 16, 0);
        wait_ready(polls);
        for (int p = 32; p < 64; p++) begin
            write_bytes(10'(p * 16), 16, p * 16);
            wait_ready(polls);
        end
        read_seq(10'h200, 515, "R7 R9 sequential sweep");

        chk(oe_bad == 0, "R11 oe moved with SCL high", oe_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule